// File: doc/BRIEF.md
# Miss-Handling Entry Controller

This block holds the control state of one outstanding cache miss. A miss on a line allocates the entry, which stores the line address, an ordering tag and a ready time, and pushes the first target onto the active target queue. Each later request that hits the same line is steered either onto the active queue, where it is served by the fill already on its way, or onto the deferred queue, where it waits for a later request. The queues themselves sit outside. This block only drives their push strobes, the source code of the pushed target, its pending mark, and the strobes that rewrite upgrade requests into full exclusive reads.

The entry moves through three states. The transitions are ALLOC (IDLE to WAIT), ISSUE (WAIT to SVC, when the request goes downstream) and FREE (WAIT or SVC to IDLE, once the active queue is empty). While the entry is in SVC it tracks four conditions: a writable copy is on its way (pending-modified), a snoop has taken the copy away (post-invalidate), a snoop has made the copy shared (post-downgrade), and a downstream cache still holds the request unissued (downstream-pending). A forward flag can also be set. Every snoop to the line gets a handled or not-handled verdict. The entry can also append the snoop as a target, promise a response, or report that sharers exist. Illegal operations are suppressed and raise a sticky error.

Top module: `mhe_ctrl`

## Requirements
- R1: After reset the entry is IDLE. All flags and strobes are low, err is low, and line_addr, order_tag and ready_time are zero. An idle entry with no alloc_vld pushes nothing and handles no snoop.
- R2: ALLOC stores alloc_line, alloc_order and alloc_ready. It clears in-service, downstream-pending, forward, pending-modified and both post flags. In the same cycle it pushes an active target with act_mark_pend=1, and act_src is 1 (prefetch) when alloc_pf is high, else 0 (CPU).
- R3: A request goes to the deferred queue if any of these holds: it is a maintenance request, the head target (captured at ALLOC) is a maintenance request, a target has been deferred since ALLOC, or the entry is in SVC and post-invalidate is set. It is also deferred if the entry is in SVC, the request needs writable, and pending-modified is clear, post-downgrade is set or forward is set. Otherwise it is pushed as an active target with act_src=0. fwd_set raises the forward flag while the entry is busy.
- R4: def_upg_rw pulses with a deferred push when the entry is in SVC, post-invalidate is set and the request is an upgrade.
- R5: An active request push has act_mark_pend high exactly when the entry is not in SVC.
- R6: ISSUE (legal only from WAIT) enters SVC. It sets pending-modified to the OR of issue_mod_hint and the needs-writable flag of the active targets (ALLOC target and later active pushes), and clears both post flags.
- R7: A snoop is not handled (snp_handled=0) when the entry is in WAIT, or when it is an express snoop while downstream-pending is set. In that case act_upg_rw_all and def_upg_rw_all both pulse if the snoop needs writable or is a cache-invalidate operation.
- R8: In the other cases a snoop that needs writable or is a cache-invalidate operation pulses def_upg_rw_all only. If post-invalidate is set, or the head target is a cache-invalidate operation, the snoop is handled and changes nothing else.
- R9: Otherwise, when pending-modified is set or the snoop invalidates, the snoop is pushed as an active target with act_src=2. Its act_mark_pend is downstream-pending AND the needs-writable flag. snp_will_resp is high when pending-modified is set, snp_resp is high and snp_clean is low. A snoop that needs writable or invalidates sets post-invalidate.
- R10: In that same case, a snoop that needs no writable copy and is cacheable sets post-downgrade and raises snp_sharers.
- R11: FREE requires act_empty high and returns the entry to IDLE.
- R12: These are violations: more than one operation in a cycle, ALLOC while busy, any other operation while IDLE, ISSUE while in SVC, and FREE while act_empty is low. A violation performs nothing and sets err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_vld | input | 1 | Allocate the entry for a missed line |
| alloc_line | input | LINE_AW | Line address of the miss |
| alloc_order | input | ORDER_W | Ordering tag of the first target |
| alloc_ready | input | TIME_W | Ready time of the first target |
| alloc_pf | input | 1 | First target is a hardware prefetch |
| alloc_wr | input | 1 | First target needs a writable copy |
| alloc_cmo | input | 1 | First target is a maintenance request |
| alloc_cinv | input | 1 | First target is a cache-invalidate operation |
| req_vld | input | 1 | Later request to the same line |
| req_wr | input | 1 | Request needs a writable copy |
| req_cmo | input | 1 | Request is a maintenance request |
| req_upg | input | 1 | Request is an upgrade |
| issue_vld | input | 1 | Request sent downstream |
| issue_mod_hint | input | 1 | A modified response is expected anyway |
| snp_vld | input | 1 | Snoop to the line |
| snp_wr | input | 1 | Snoop needs a writable copy |
| snp_inval | input | 1 | Snoop invalidates |
| snp_cinv | input | 1 | Snoop is a cache-invalidate operation |
| snp_express | input | 1 | Snoop is an express snoop |
| snp_resp | input | 1 | Snoop expects a response |
| snp_clean | input | 1 | Snoop is a clean operation |
| snp_uncache | input | 1 | Snoop is uncacheable |
| dn_pend_set | input | 1 | Raise downstream-pending (busy only) |
| dn_pend_clr | input | 1 | Clear downstream-pending (wins over set) |
| fwd_set | input | 1 | Raise the forward flag (busy only) |
| dealloc_vld | input | 1 | Free the entry |
| act_empty | input | 1 | Active target queue is empty |
| act_push | output | 1 | Push onto the active target queue |
| act_src | output | 2 | Source of pushed target: 0 CPU, 1 prefetch, 2 snoop |
| act_mark_pend | output | 1 | Pushed active target is marked pending |
| def_push | output | 1 | Push onto the deferred queue |
| def_upg_rw | output | 1 | Rewrite the upgrade of the deferred target |
| act_upg_rw_all | output | 1 | Rewrite all upgrades in the active queue |
| def_upg_rw_all | output | 1 | Rewrite all upgrades in the deferred queue |
| snp_handled | output | 1 | Snoop is handled by the entry |
| snp_will_resp | output | 1 | Entry will respond to the snoop |
| snp_sharers | output | 1 | Indicate sharers to the snooper |
| busy | output | 1 | Entry is allocated |
| in_service | output | 1 | Entry is in SVC |
| pend_mod | output | 1 | Pending-modified flag |
| post_inv | output | 1 | Post-invalidate flag |
| post_dgr | output | 1 | Post-downgrade flag |
| dn_pend | output | 1 | Downstream-pending flag |
| line_addr | output | LINE_AW | Stored line address |
| order_tag | output | ORDER_W | Stored ordering tag |
| ready_time | output | TIME_W | Stored ready time |
| err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest cases to reach are the deferral and snoop branches in SVC. They depend on a flag history: post-invalidate or post-downgrade must have been set by an earlier snoop, pending-modified must follow from the needs-writable history at ISSUE, and downstream-pending and forward must be raised with their side inputs. The stimulus builds each history on purpose. It allocates, issues with and without a writable target, sends a downgrading or invalidating snoop, and only then presents the request or snoop under test. Mid-run resets give each violation type a clean err flag. A behavioural model checks every output on every cycle.

// File: rtl/mhe_pkg.sv
package mhe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SVC  = 2'd2
    } mhe_state_e;

    typedef enum logic [1:0] {
        SRC_CPU = 2'd0,
        SRC_PF  = 2'd1,
        SRC_SNP = 2'd2
    } mhe_src_e;
endpackage

// File: rtl/mhe_defer_dec.sv
module mhe_defer_dec (
    input  logic req_cmo,
    input  logic req_wr,
    input  logic req_upg,
    input  logic head_cmo,
    input  logic def_nonempty,
    input  logic in_svc,
    input  logic post_inv,
    input  logic post_dgr,
    input  logic pend_mod,
    input  logic fwd,
    output logic defer,
    output logic upg_rw
);
    logic svc_block;
    logic wr_block;

    // In service: a writable request cannot ride on this fill.
    always_comb begin
        wr_block  = req_wr & (~pend_mod | post_dgr | fwd);
        svc_block = in_svc & (post_inv | wr_block);
        defer     = req_cmo | head_cmo | def_nonempty | svc_block;
        upg_rw    = defer & in_svc & post_inv & req_upg;
    end
endmodule

// File: rtl/mhe_snoop_dec.sv
module mhe_snoop_dec (
    input  logic in_svc,
    input  logic dn_pend,
    input  logic pend_mod,
    input  logic post_inv,
    input  logic head_cinv,
    input  logic snp_wr,
    input  logic snp_inval,
    input  logic snp_cinv,
    input  logic snp_express,
    input  logic snp_resp,
    input  logic snp_clean,
    input  logic snp_uncache,
    output logic handled,
    output logic rw_act,
    output logic rw_def,
    output logic push,
    output logic will_resp,
    output logic set_pinv,
    output logic set_pdgr
);
    logic kills_copy;
    logic precedes;
    logic already_gone;

    always_comb begin
        kills_copy   = snp_wr | snp_cinv;
        precedes     = ~in_svc | (snp_express & dn_pend);
        already_gone = post_inv | head_cinv;
        handled      = 1'b0;
        rw_act       = 1'b0;
        rw_def       = 1'b0;
        push         = 1'b0;
        will_resp    = 1'b0;
        set_pinv     = 1'b0;
        set_pdgr     = 1'b0;
        if (precedes) begin
            rw_act = kills_copy;
            rw_def = kills_copy;
        end else begin
            handled = 1'b1;
            rw_def  = kills_copy;
            if (!already_gone) begin
                push      = pend_mod | snp_inval;
                will_resp = pend_mod & snp_resp & ~snp_clean;
                set_pinv  = push & (snp_wr | snp_inval);
                set_pdgr  = ~snp_wr & ~snp_uncache;
            end
        end
    end
endmodule

// File: rtl/mhe_ctrl.sv
module mhe_ctrl
    import mhe_pkg::*;
#(
    parameter int LINE_AW = 40,
    parameter int ORDER_W = 16,
    parameter int TIME_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_vld,
    input  logic [LINE_AW-1:0] alloc_line,
    input  logic [ORDER_W-1:0] alloc_order,
    input  logic [TIME_W-1:0]  alloc_ready,
    input  logic               alloc_pf,
    input  logic               alloc_wr,
    input  logic               alloc_cmo,
    input  logic               alloc_cinv,
    input  logic               req_vld,
    input  logic               req_wr,
    input  logic               req_cmo,
    input  logic               req_upg,
    input  logic               issue_vld,
    input  logic               issue_mod_hint,
    input  logic               snp_vld,
    input  logic               snp_wr,
    input  logic               snp_inval,
    input  logic               snp_cinv,
    input  logic               snp_express,
    input  logic               snp_resp,
    input  logic               snp_clean,
    input  logic               snp_uncache,
    input  logic               dn_pend_set,
    input  logic               dn_pend_clr,
    input  logic               fwd_set,
    input  logic               dealloc_vld,
    input  logic               act_empty,
    output logic               act_push,
    output logic [1:0]         act_src,
    output logic               act_mark_pend,
    output logic               def_push,
    output logic               def_upg_rw,
    output logic               act_upg_rw_all,
    output logic               def_upg_rw_all,
    output logic               snp_handled,
    output logic               snp_will_resp,
    output logic               snp_sharers,
    output logic               busy,
    output logic               in_service,
    output logic               pend_mod,
    output logic               post_inv,
    output logic               post_dgr,
    output logic               dn_pend,
    output logic [LINE_AW-1:0] line_addr,
    output logic [ORDER_W-1:0] order_tag,
    output logic [TIME_W-1:0]  ready_time,
    output logic               err
);
    localparam int NUM_OPS = 5;
    localparam int OPC_W   = $clog2(NUM_OPS + 1);

    mhe_state_e st_q, st_d;

    logic [LINE_AW-1:0] line_q;
    logic [ORDER_W-1:0] order_q;
    logic [TIME_W-1:0]  ready_q;
    logic nw_q, hcmo_q, hcinv_q, defany_q;
    logic pm_q, pinv_q, pdgr_q, dp_q, fwd_q, err_q;

    logic [OPC_W-1:0] op_cnt;
    logic is_busy, is_svc, viol;
    logic do_alloc, do_req, do_issue, do_snp, do_free;

    logic dd_defer, dd_upg_rw;
    logic sd_handled, sd_rw_act, sd_rw_def, sd_push;
    logic sd_will, sd_set_pinv, sd_set_pdgr;

    // Operation legality
    always_comb begin
        op_cnt = OPC_W'(alloc_vld) + OPC_W'(req_vld) + OPC_W'(issue_vld)
               + OPC_W'(snp_vld) + OPC_W'(dealloc_vld);
        is_busy = (st_q != ST_IDLE);
        is_svc  = (st_q == ST_SVC);
        viol = (op_cnt > OPC_W'(1))
             | (alloc_vld & is_busy)
             | ((req_vld | issue_vld | snp_vld | dealloc_vld) & ~is_busy)
             | (issue_vld & is_svc)
             | (dealloc_vld & ~act_empty);
        do_alloc = alloc_vld   & ~viol;
        do_req   = req_vld     & ~viol;
        do_issue = issue_vld   & ~viol;
        do_snp   = snp_vld     & ~viol;
        do_free  = dealloc_vld & ~viol;
    end

    mhe_defer_dec u_defer (
        .req_cmo      (req_cmo),
        .req_wr       (req_wr),
        .req_upg      (req_upg),
        .head_cmo     (hcmo_q),
        .def_nonempty (defany_q),
        .in_svc       (is_svc),
        .post_inv     (pinv_q),
        .post_dgr     (pdgr_q),
        .pend_mod     (pm_q),
        .fwd          (fwd_q),
        .defer        (dd_defer),
        .upg_rw       (dd_upg_rw)
    );

    mhe_snoop_dec u_snoop (
        .in_svc      (is_svc),
        .dn_pend     (dp_q),
        .pend_mod    (pm_q),
        .post_inv    (pinv_q),
        .head_cinv   (hcinv_q),
        .snp_wr      (snp_wr),
        .snp_inval   (snp_inval),
        .snp_cinv    (snp_cinv),
        .snp_express (snp_express),
        .snp_resp    (snp_resp),
        .snp_clean   (snp_clean),
        .snp_uncache (snp_uncache),
        .handled     (sd_handled),
        .rw_act      (sd_rw_act),
        .rw_def      (sd_rw_def),
        .push        (sd_push),
        .will_resp   (sd_will),
        .set_pinv    (sd_set_pinv),
        .set_pdgr    (sd_set_pdgr)
    );

    // Next state: ALLOC, ISSUE, FREE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (do_alloc) st_d = ST_WAIT;
            ST_WAIT: begin
                if (do_issue)     st_d = ST_SVC;
                else if (do_free) st_d = ST_IDLE;
            end
            ST_SVC:  if (do_free) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Entry context and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q   <= '0;
            order_q  <= '0;
            ready_q  <= '0;
            nw_q     <= 1'b0;
            hcmo_q   <= 1'b0;
            hcinv_q  <= 1'b0;
            defany_q <= 1'b0;
            pm_q     <= 1'b0;
            pinv_q   <= 1'b0;
            pdgr_q   <= 1'b0;
            dp_q     <= 1'b0;
            fwd_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (viol) err_q <= 1'b1;
            if (do_alloc) begin
                line_q   <= alloc_line;
                order_q  <= alloc_order;
                ready_q  <= alloc_ready;
                nw_q     <= alloc_wr;
                hcmo_q   <= alloc_cmo;
                hcinv_q  <= alloc_cinv;
                defany_q <= 1'b0;
                pm_q     <= 1'b0;
                pinv_q   <= 1'b0;
                pdgr_q   <= 1'b0;
                dp_q     <= 1'b0;
                fwd_q    <= 1'b0;
            end else begin
                if (is_busy) begin
                    if (dn_pend_clr)      dp_q <= 1'b0;
                    else if (dn_pend_set) dp_q <= 1'b1;
                    if (fwd_set) fwd_q <= 1'b1;
                end
                if (do_req) begin
                    if (dd_defer) defany_q <= 1'b1;
                    else if (req_wr) nw_q <= 1'b1;
                end
                if (do_issue) begin
                    pm_q   <= nw_q | issue_mod_hint;
                    pinv_q <= 1'b0;
                    pdgr_q <= 1'b0;
                end
                if (do_snp) begin
                    if (sd_set_pinv) pinv_q <= 1'b1;
                    if (sd_set_pdgr) pdgr_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        act_push       = 1'b0;
        act_src        = SRC_CPU;
        act_mark_pend  = 1'b0;
        def_push       = 1'b0;
        def_upg_rw     = 1'b0;
        act_upg_rw_all = 1'b0;
        def_upg_rw_all = 1'b0;
        snp_handled    = 1'b0;
        snp_will_resp  = 1'b0;
        snp_sharers    = 1'b0;
        if (do_alloc) begin
            act_push      = 1'b1;
            act_src       = alloc_pf ? SRC_PF : SRC_CPU;
            act_mark_pend = 1'b1;
        end else if (do_req) begin
            def_push      = dd_defer;
            def_upg_rw    = dd_upg_rw;
            act_push      = ~dd_defer;
            act_mark_pend = ~dd_defer & ~is_svc;
        end else if (do_snp) begin
            snp_handled    = sd_handled;
            act_upg_rw_all = sd_rw_act;
            def_upg_rw_all = sd_rw_def;
            act_push       = sd_push;
            act_src        = sd_push ? SRC_SNP : SRC_CPU;
            act_mark_pend  = sd_push & dp_q & nw_q;
            snp_will_resp  = sd_will;
            snp_sharers    = sd_set_pdgr;
        end
        busy       = is_busy;
        in_service = is_svc;
        pend_mod   = pm_q;
        post_inv   = pinv_q;
        post_dgr   = pdgr_q;
        dn_pend    = dp_q;
        line_addr  = line_q;
        order_tag  = order_q;
        ready_time = ready_q;
        err        = err_q;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !alloc_vld) |-> (!act_push && !def_push && !snp_handled));

    assert_one_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_push, def_push}));

    assert_issue_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_service) |-> (!post_inv && !post_dgr));

    assert_unhandled_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && !snp_handled) |-> (!act_push && !def_push));

    assert_will_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_will_resp |-> (act_push && pend_mod));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: tb/tb_mhe_ctrl.sv
module tb_mhe_ctrl;
    localparam int AW = 40;
    localparam int OW = 16;
    localparam int TW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          alloc_vld, alloc_pf, alloc_wr, alloc_cmo, alloc_cinv;
    logic [AW-1:0] alloc_line;
    logic [OW-1:0] alloc_order;
    logic [TW-1:0] alloc_ready;
    logic req_vld, req_wr, req_cmo, req_upg, issue_vld, issue_mod_hint;
    logic snp_vld, snp_wr, snp_inval, snp_cinv, snp_express, snp_resp, snp_clean, snp_uncache;
    logic dn_pend_set, dn_pend_clr, fwd_set, dealloc_vld, act_empty;
    logic act_push, act_mark_pend, def_push, def_upg_rw, act_upg_rw_all, def_upg_rw_all;
    logic [1:0] act_src;
    logic snp_handled, snp_will_resp, snp_sharers, busy, in_service;
    logic pend_mod, post_inv, post_dgr, dn_pend, err;
    logic [AW-1:0] line_addr;
    logic [OW-1:0] order_tag;
    logic [TW-1:0] ready_time;

    mhe_ctrl #(.LINE_AW(AW), .ORDER_W(OW), .TIME_W(TW)) dut (.*);

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    int      m_st;
    bit [AW-1:0] m_line;
    bit [OW-1:0] m_order;
    bit [TW-1:0] m_ready;
    bit m_nw, m_hcmo, m_hcinv, m_dany, m_pm, m_pinv, m_pdgr, m_dp, m_fwd, m_err;

    task automatic model_reset();
        m_st = 0; m_line = '0; m_order = '0; m_ready = '0;
        {m_nw, m_hcmo, m_hcinv, m_dany, m_pm, m_pinv, m_pdgr, m_dp, m_fwd, m_err} = '0;
    endtask

    task automatic clear_in();
        {alloc_vld, alloc_pf, alloc_wr, alloc_cmo, alloc_cinv} = '0;
        alloc_line = '0; alloc_order = '0; alloc_ready = '0;
        {req_vld, req_wr, req_cmo, req_upg, issue_vld, issue_mod_hint} = '0;
        {snp_vld, snp_wr, snp_inval, snp_cinv, snp_express, snp_resp, snp_clean, snp_uncache} = '0;
        {dn_pend_set, dn_pend_clr, fwd_set, dealloc_vld, act_empty} = '0;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic step(input string tag);
        bit e_ap, e_mp, e_dp, e_urw, e_rwa, e_rwd, e_h, e_wr, e_sh;
        bit [1:0] e_src;
        bit bad, is_busy, is_svc, dfr;
        int nops;
        bit n_pinv, n_pdgr;
        logic [105:0] got, exp;
        {e_ap, e_mp, e_dp, e_urw, e_rwa, e_rwd, e_h, e_wr, e_sh} = '0;
        e_src = 2'd0; n_pinv = m_pinv; n_pdgr = m_pdgr; dfr = 0;
        #1;
        nops = int'(alloc_vld) + int'(req_vld) + int'(issue_vld) + int'(snp_vld) + int'(dealloc_vld);
        is_busy = (m_st != 0);
        is_svc  = (m_st == 2);
        bad = (nops > 1) || (alloc_vld && is_busy)
           || ((req_vld || issue_vld || snp_vld || dealloc_vld) && !is_busy)
           || (issue_vld && is_svc) || (dealloc_vld && !act_empty);
        if (!bad && alloc_vld) begin
            e_ap = 1; e_mp = 1; e_src = alloc_pf ? 2'd1 : 2'd0;
        end
        if (!bad && req_vld) begin
            dfr = req_cmo || m_hcmo || m_dany;
            if (is_svc && m_pinv) dfr = 1;
            if (is_svc && req_wr && (!m_pm || m_pdgr || m_fwd)) dfr = 1;
            if (dfr) begin
                e_dp = 1; e_urw = is_svc && m_pinv && req_upg;
            end else begin
                e_ap = 1; e_mp = !is_svc;
            end
        end
        if (!bad && snp_vld) begin
            if (!is_svc || (snp_express && m_dp)) begin
                e_rwa = snp_wr || snp_cinv; e_rwd = e_rwa;
            end else begin
                e_h = 1; e_rwd = snp_wr || snp_cinv;
                if (!(m_pinv || m_hcinv)) begin
                    if (m_pm || snp_inval) begin
                        e_ap = 1; e_src = 2'd2; e_mp = m_dp && m_nw;
                        e_wr = m_pm && snp_resp && !snp_clean;
                        if (snp_wr || snp_inval) n_pinv = 1;
                    end
                    if (!snp_wr && !snp_uncache) begin
                        n_pdgr = 1; e_sh = 1;
                    end
                end
            end
        end
        got = {act_push, act_src, act_mark_pend, def_push, def_upg_rw, act_upg_rw_all,
               def_upg_rw_all, snp_handled, snp_will_resp, snp_sharers, busy, in_service,
               pend_mod, post_inv, post_dgr, dn_pend, err, line_addr, order_tag, ready_time};
        exp = {e_ap, e_src, e_mp, e_dp, e_urw, e_rwa, e_rwd, e_h, e_wr, e_sh,
               is_busy, is_svc, m_pm, m_pinv, m_pdgr, m_dp, m_err, m_line, m_order, m_ready};
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
        @(posedge clk);
        if (bad) m_err = 1;
        if (!bad && alloc_vld) begin
            m_st = 1; m_line = alloc_line; m_order = alloc_order; m_ready = alloc_ready;
            m_nw = alloc_wr; m_hcmo = alloc_cmo; m_hcinv = alloc_cinv;
            {m_dany, m_pm, m_pinv, m_pdgr, m_dp, m_fwd} = '0;
        end else begin
            if (is_busy) begin
                if (dn_pend_clr) m_dp = 0;
                else if (dn_pend_set) m_dp = 1;
                if (fwd_set) m_fwd = 1;
            end
            if (!bad && req_vld) begin
                if (dfr) m_dany = 1;
                else if (req_wr) m_nw = 1;
            end
            if (!bad && issue_vld) begin
                m_st = 2; m_pm = m_nw || issue_mod_hint; m_pinv = 0; m_pdgr = 0;
            end
            if (!bad && snp_vld) begin
                m_pinv = n_pinv; m_pdgr = n_pdgr;
            end
            if (!bad && dealloc_vld) m_st = 0;
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic alloc(input bit pf, input bit wr, input bit cmo, input bit cinv,
                         input logic [AW-1:0] a, input string tag);
        alloc_vld = 1; alloc_pf = pf; alloc_wr = wr; alloc_cmo = cmo; alloc_cinv = cinv;
        alloc_line = a; alloc_order = a[15:0] ^ 16'h5a5a; alloc_ready = a[31:0] + 32'd77;
        step(tag);
    endtask

    task automatic req(input bit wr, input bit cmo, input bit upg, input string tag);
        req_vld = 1; req_wr = wr; req_cmo = cmo; req_upg = upg;
        step(tag);
    endtask

    task automatic issue(input bit hint, input string tag);
        issue_vld = 1; issue_mod_hint = hint;
        step(tag);
    endtask

    task automatic snoop(input bit wr, input bit inv, input bit cinv, input bit exp_s,
                         input bit resp, input bit cln, input bit unc, input string tag);
        snp_vld = 1; snp_wr = wr; snp_inval = inv; snp_cinv = cinv; snp_express = exp_s;
        snp_resp = resp; snp_clean = cln; snp_uncache = unc;
        step(tag);
    endtask

    task automatic free_entry(input bit empty, input string tag);
        dealloc_vld = 1; act_empty = empty;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL R1: watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        step("R1 reset state");
        step("R1 idle quiet");
        // Entry A: read miss, flags via snoops
        alloc(0, 0, 0, 0, 40'h12_3456_7890, "R2 alloc cpu");
        req(0, 0, 0, "R5 active push in wait marked pending");
        snoop(1, 1, 0, 0, 1, 0, 0, "R7 snoop before issue not handled");
        dn_pend_set = 1; step("R7 set downstream pending");
        issue(0, "R6 issue no writable");
        req(1, 0, 0, "R3 writable request deferred no pend-mod");
        req(0, 0, 0, "R3 deferred list nonempty");
        snoop(0, 0, 0, 0, 1, 0, 0, "R10 read snoop downgrades");
        snoop(0, 0, 1, 1, 0, 0, 0, "R7 express snoop with downstream pending");
        dn_pend_clr = 1; step("R7 clear downstream pending");
        snoop(1, 1, 0, 0, 1, 0, 0, "R9 invalidating snoop appended");
        req(0, 0, 1, "R4 upgrade rewritten on deferral");
        snoop(1, 1, 0, 0, 1, 0, 0, "R8 snoop after post-invalidate");
        free_entry(1, "R11 free to idle");
        step("R11 idle after free");
        // Entry B: prefetch with writable, snoops while pending-modified
        alloc(1, 1, 0, 0, 40'h00_0000_1240, "R2 alloc prefetch");
        req(0, 0, 0, "R5 active push before issue");
        issue(0, "R6 pend-mod from needs-writable");
        snoop(0, 0, 0, 0, 1, 0, 0, "R9 will respond read snoop");
        dn_pend_set = 1; step("R9 set downstream pending");
        snoop(0, 0, 0, 0, 1, 1, 0, "R9 clean snoop no response marked pending");
        snoop(0, 0, 0, 0, 1, 0, 1, "R10 uncacheable snoop no sharers");
        free_entry(1, "R11 free B");
        // Entry C: writable request joins, then forward defers
        alloc(0, 0, 0, 0, 40'hab_cdef_0100, "R2 alloc C");
        issue(1, "R6 pend-mod from hint");
        req(1, 0, 0, "R5 writable joins active unmarked");
        fwd_set = 1; step("R3 raise forward");
        req(1, 0, 0, "R3 forward defers writable");
        free_entry(1, "R11 free C");
        // Entry D: maintenance head
        alloc(0, 0, 1, 0, 40'h00_0000_2000, "R2 alloc maintenance head");
        req(0, 0, 0, "R3 head maintenance defers");
        free_entry(1, "R11 free D");
        // Entry E: maintenance request and cache-invalidate head
        alloc(0, 0, 0, 1, 40'h00_0000_3000, "R2 alloc invalidate head");
        req(0, 1, 0, "R3 maintenance request deferred");
        issue(0, "R6 issue E");
        snoop(0, 1, 0, 0, 1, 0, 0, "R8 invalidate head handled early");
        free_entry(0, "R12 free with targets left");
        step("R12 error sticky");
        free_entry(1, "R11 free E");
        // Violations from a clean reset
        do_reset();
        alloc_vld = 1; req_vld = 1; alloc_line = 40'h55; step("R12 two ops one cycle");
        step("R12 nothing allocated");
        do_reset();
        issue(0, "R12 issue while idle");
        do_reset();
        alloc(0, 0, 0, 0, 40'h77_0000_0040, "R2 alloc F");
        alloc(0, 0, 0, 0, 40'h99, "R12 alloc while busy");
        issue(0, "R6 issue F");
        issue(0, "R12 issue while in service");
        step("R12 final state");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule